// File: doc/BRIEF.md
# Multiplexed Parallel Bus Master

This block runs single-byte read and write transactions to one of two peripheral chips over a shared 8-bit bus. Address and data travel on the same lines. A client hands over one request at a time through a valid/ready handshake. Each request carries a 16-bit address, a direction flag, a write byte, a chip index and an access-space flag. The engine then sequences the bus in fixed phases:

1. It places the low address byte on the lines with the low latch strobe raised.
2. It drops that strobe.
3. It does the same for the high byte with the high latch strobe.
4. It drives the write byte, or releases the lines for a read.
5. It pulls the selected chip select low.
6. It pulls the read or write strobe low.
7. It waits for the peripheral's active-low acknowledge.

When the acknowledge arrives or the wait runs out, every select and strobe returns high. A one-cycle done pulse then carries the captured byte, a timeout flag and an indication of whether the access space changed since the previous transaction.

Each address, data and select phase lasts `PHASE_CYC` clocks. The acknowledge wait is bounded by `TIMEOUT_CYC` clocks. Both limits are parameters, so one netlist suits peripherals of different speeds.

Top module: `mux_bus_master`

## Requirements
- R1: After reset and whenever idle: `cs_n_o` is 2'b11, `rd_n_o` and `wr_n_o` are 1, both latch strobes are 0, `bus_data_oe_o` is 0, `req_ready_o` is 1 and `done_o` is 0.
- R2: After a request is accepted, the engine drives address bits 7:0 with `oe` high for 2×PHASE_CYC cycles. `addr_lo_stb_o` is high for the first PHASE_CYC of those cycles. It then drives bits 15:8 the same way, with `addr_hi_stb_o` high for the first PHASE_CYC cycles. Throughout these phases the selects and strobes stay high.
- R3: The next PHASE_CYC cycles form the data phase, with selects and strobes still high. A write drives `req_wdata_i` with `oe` high. A read holds `oe` low from this phase until the transaction ends.
- R4: The next PHASE_CYC cycles form the select phase. Exactly one select goes low: chip index 0 lowers `cs_n_o[0]` and index 1 lowers `cs_n_o[1]`. It stays low through the strobe phase.
- R5: The strobe phase follows the select phase. A read (`req_write_i`=0) lowers `rd_n_o` and a write (`req_write_i`=1) lowers `wr_n_o`. The two are never low together, and the lines are never driven while `rd_n_o` is low.
- R6: When `ack_n_i` is sampled low at a clock edge in the strobe phase, the next cycle is the done cycle. In that cycle all selects and strobes are high, `done_rdata_o` equals `bus_data_i` from that edge, and `done_timeout_o` is 0.
- R7: If `ack_n_i` stays high for TIMEOUT_CYC strobe cycles, the next cycle is the done cycle with `done_timeout_o`=1 and `done_rdata_o`=0. An acknowledge seen in the last allowed cycle still counts as success.
- R8: `req_ready_o` is high only when idle. A request held valid during a transaction is not accepted and does not alter it.
- R9: `done_space_chg_o` is 1 when this transaction's `req_space_i` differs from that of the previously accepted transaction. Space 0 is attribute memory and 1 is control registers. The remembered space is 0 after reset.
- R10: `done_o` is high for exactly one cycle per transaction and is followed by an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_addr_i | input | 16 | Target address |
| req_write_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 8 | Write byte |
| req_chip_i | input | 1 | Chip select index |
| req_space_i | input | 1 | Access space: 0 attribute memory, 1 control registers |
| done_o | output | 1 | One-cycle completion pulse |
| done_rdata_o | output | 8 | Captured read byte |
| done_timeout_o | output | 1 | Acknowledge wait expired |
| done_space_chg_o | output | 1 | Access space differs from previous transaction |
| bus_data_o | output | 8 | Shared bus lines, output value |
| bus_data_oe_o | output | 1 | Shared bus drive enable |
| bus_data_i | input | 8 | Shared bus lines, input value |
| addr_lo_stb_o | output | 1 | Low address byte latch strobe |
| addr_hi_stb_o | output | 1 | High address byte latch strobe |
| cs_n_o | output | 2 | Chip selects, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ack_n_i | input | 1 | Peripheral acknowledge, active low |

## Verification
The bench builds the block with PHASE_CYC=2 and TIMEOUT_CYC=6. With these values every phase boundary can be checked cycle by cycle. It also makes it cheap to sweep the acknowledge arrival across every strobe cycle and beyond the limit, including an acknowledge in the final allowed cycle. That sweep runs for both chip indices and both directions, with the access space varied so that changes and repeats both occur.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALO,
    ST_ALO_GAP,
    ST_AHI,
    ST_AHI_GAP,
    ST_DATA,
    ST_CSEL,
    ST_STRB,
    ST_DONE
  } mbm_state_e;
endpackage

// File: rtl/mbm_phase_timer.sv
module mbm_phase_timer #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int PW = $clog2(PHASE_CYC + 1);
  logic [PW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == PW'(PHASE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < PW'(PHASE_CYC)); // R2
endmodule

// File: rtl/mbm_ack_watch.sv
module mbm_ack_watch #(
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ack_n_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  logic [TW-1:0] wait_q;

  assign hit_o    = run_i && !ack_n_i;
  assign expire_o = run_i && ack_n_i && (wait_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             wait_q <= '0;
    else if (!run_i || hit_o || expire_o)    wait_q <= '0;
    else                                     wait_q <= wait_q + 1'b1;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q < TW'(TIMEOUT_CYC)); // R7
  AST_HIT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && expire_o)); // R7
endmodule

// File: rtl/mbm_space_track.sv
module mbm_space_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic space_i,
  output logic chg_o
);
  logic last_q;
  logic chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      chg_q  <= 1'b0;
    end else if (accept_i) begin
      chg_q  <= (space_i != last_q);
      last_q <= space_i;
    end
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_CS      = 2,
  parameter int PHASE_CYC   = 4,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [2*DATA_W-1:0]  req_addr_i,
  input  logic                 req_write_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  input  logic [(NUM_CS>1 ? $clog2(NUM_CS) : 1)-1:0] req_chip_i,
  input  logic                 req_space_i,
  output logic                 done_o,
  output logic [DATA_W-1:0]    done_rdata_o,
  output logic                 done_timeout_o,
  output logic                 done_space_chg_o,
  output logic [DATA_W-1:0]    bus_data_o,
  output logic                 bus_data_oe_o,
  input  logic [DATA_W-1:0]    bus_data_i,
  output logic                 addr_lo_stb_o,
  output logic                 addr_hi_stb_o,
  output logic [NUM_CS-1:0]    cs_n_o,
  output logic                 rd_n_o,
  output logic                 wr_n_o,
  input  logic                 ack_n_i
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int CSW    = NUM_CS > 1 ? $clog2(NUM_CS) : 1;

  mbm_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CSW-1:0]    chip_q;
  logic              wr_q, tmo_q;
  logic              accept, ph_run, ph_last, strb, sel, ack_hit, ack_exp;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign ph_run = (state_q inside {ST_ALO, ST_ALO_GAP, ST_AHI, ST_AHI_GAP, ST_DATA, ST_CSEL});
  assign strb   = (state_q == ST_STRB);
  assign sel    = (state_q == ST_CSEL) || strb;

  mbm_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_phase (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (ph_run), .last_o (ph_last)
  );

  mbm_ack_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ack (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (strb), .ack_n_i (ack_n_i),
    .hit_o (ack_hit), .expire_o (ack_exp)
  );

  mbm_space_track u_space (
    .clk_i (clk_i), .rst_ni (rst_ni), .accept_i (accept),
    .space_i (req_space_i), .chg_o (done_space_chg_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_ALO;
      ST_ALO:     if (ph_last) state_d = ST_ALO_GAP;
      ST_ALO_GAP: if (ph_last) state_d = ST_AHI;
      ST_AHI:     if (ph_last) state_d = ST_AHI_GAP;
      ST_AHI_GAP: if (ph_last) state_d = ST_DATA;
      ST_DATA:    if (ph_last) state_d = ST_CSEL;
      ST_CSEL:    if (ph_last) state_d = ST_STRB;
      ST_STRB:    if (ack_hit || ack_exp) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      chip_q  <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        chip_q  <= req_chip_i;
        wr_q    <= req_write_i;
      end
      if (ack_hit) begin
        rdata_q <= bus_data_i;
        tmo_q   <= 1'b0;
      end else if (ack_exp) begin
        rdata_q <= '0;
        tmo_q   <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_data_o    = '0;
    bus_data_oe_o = 1'b0;
    unique case (state_q)
      ST_ALO, ST_ALO_GAP: begin
        bus_data_o    = addr_q[DATA_W-1:0];
        bus_data_oe_o = 1'b1;
      end
      ST_AHI, ST_AHI_GAP: begin
        bus_data_o    = addr_q[ADDR_W-1:DATA_W];
        bus_data_oe_o = 1'b1;
      end
      ST_DATA, ST_CSEL, ST_STRB: begin
        bus_data_o    = wr_q ? wdata_q : '0;
        bus_data_oe_o = wr_q;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = !(sel && (chip_q == CSW'(i)));
  end

  assign addr_lo_stb_o  = (state_q == ST_ALO);
  assign addr_hi_stb_o  = (state_q == ST_AHI);
  assign rd_n_o         = !(strb && !wr_q);
  assign wr_n_o         = !(strb && wr_q);
  assign req_ready_o    = (state_q == ST_IDLE);
  assign done_o         = (state_q == ST_DONE);
  assign done_rdata_o   = rdata_q;
  assign done_timeout_o = tmo_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (&cs_n_o && rd_n_o && wr_n_o && !bus_data_oe_o)); // R1
  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_lo_stb_o && addr_hi_stb_o)); // R2
  AST_CS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1); // R4
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> !(&cs_n_o)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o)); // R5
  AST_NO_DRIVE_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !bus_data_oe_o); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&cs_n_o && rd_n_o && wr_n_o)); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !done_o) |=> !req_ready_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o)); // R10
endmodule

// File: tb/mux_bus_master_tb.sv
module mux_bus_master_tb;
  localparam int P = 2;
  localparam int T = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_wdata_i = '0;
  logic [0:0]  req_chip_i = '0;
  logic        req_space_i = 1'b0;
  logic        done_o;
  logic [7:0]  done_rdata_o;
  logic        done_timeout_o;
  logic        done_space_chg_o;
  logic [7:0]  bus_data_o;
  logic        bus_data_oe_o;
  logic [7:0]  bus_data_i = 8'h00;
  logic        addr_lo_stb_o, addr_hi_stb_o;
  logic [1:0]  cs_n_o;
  logic        rd_n_o, wr_n_o;
  logic        ack_n_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit prev_space = 1'b0;

  always #10 clk_i = ~clk_i;

  mux_bus_master #(.DATA_W(8), .NUM_CS(2), .PHASE_CYC(P), .TIMEOUT_CYC(T)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_write_i,
    .req_wdata_i, .req_chip_i, .req_space_i, .done_o, .done_rdata_o,
    .done_timeout_o, .done_space_chg_o, .bus_data_o, .bus_data_oe_o,
    .bus_data_i, .addr_lo_stb_o, .addr_hi_stb_o, .cs_n_o, .rd_n_o, .wr_n_o,
    .ack_n_i
  );

  function automatic logic [14:0] pk(logic lo, logic hi, logic [1:0] csn,
                                     logic rd, logic wr, logic oe, logic [7:0] d);
    return {lo, hi, csn, rd, wr, oe, oe ? d : 8'h00};
  endfunction

  function automatic logic [14:0] act_vec();
    return pk(addr_lo_stb_o, addr_hi_stb_o, cs_n_o, rd_n_o, wr_n_o, bus_data_oe_o, bus_data_o);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic vec(input string tag, input logic [14:0] exp);
    logic [14:0] a;
    a = act_vec();
    chk(a == exp, tag, 32'(a), 32'(exp));
  endtask

  task automatic txn(input logic [15:0] addr, input bit wr, input logic [7:0] wd,
                     input bit chip, input bit space, input int dly, input logic [7:0] rv);
    logic [1:0] csel;
    int slen;
    bit acked;
    csel  = chip ? 2'b01 : 2'b10;
    acked = (dly < T);
    slen  = acked ? dly + 1 : T;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8 ready idle", 32'(req_ready_o), 1);
    req_valid_i = 1'b1; req_addr_i = addr; req_write_i = wr;
    req_wdata_i = wd; req_chip_i = chip; req_space_i = space;
    bus_data_i  = ~rv;
    for (int t = 0; t < 6 * P; t++) begin
      @(negedge clk_i);
      if (t == 0) begin
        // R8: junk request held valid while busy
        req_addr_i = ~addr; req_write_i = ~wr; req_wdata_i = ~wd;
        req_chip_i = ~chip; req_space_i = ~space;
      end
      chk(req_ready_o == 1'b0, "R8 busy", 32'(req_ready_o), 0);
      if (t < P)            vec("R2 addr lo strobe", pk(1, 0, 2'b11, 1, 1, 1, addr[7:0]));
      else if (t < 2 * P)   vec("R2 addr lo hold",   pk(0, 0, 2'b11, 1, 1, 1, addr[7:0]));
      else if (t < 3 * P)   vec("R2 addr hi strobe", pk(0, 1, 2'b11, 1, 1, 1, addr[15:8]));
      else if (t < 4 * P)   vec("R2 addr hi hold",   pk(0, 0, 2'b11, 1, 1, 1, addr[15:8]));
      else if (t < 5 * P)   vec("R3 data phase",     pk(0, 0, 2'b11, 1, 1, wr, wd));
      else                  vec("R4 select phase",   pk(0, 0, csel, 1, 1, wr, wd));
    end
    for (int s = 0; s < slen; s++) begin
      @(negedge clk_i);
      vec("R5 strobe phase", pk(0, 0, csel, wr, !wr, wr, wd));
      chk(done_o == 1'b0, "R7 no early done", 32'(done_o), 0);
      if (s == dly) begin
        ack_n_i = 1'b0;
        bus_data_i = rv;
      end
    end
    @(negedge clk_i);
    chk(done_o == 1'b1, "R10 done pulse", 32'(done_o), 1);
    vec("R6 release", pk(0, 0, 2'b11, 1, 1, 0, 8'h00));
    chk(done_timeout_o == !acked, "R7 timeout flag", 32'(done_timeout_o), 32'(!acked));
    chk(done_rdata_o == (acked ? rv : 8'h00), acked ? "R6 rdata" : "R7 rdata zero",
        32'(done_rdata_o), 32'(acked ? rv : 8'h00));
    chk(done_space_chg_o == (space != prev_space), "R9 space change",
        32'(done_space_chg_o), 32'(space != prev_space));
    prev_space = space;
    ack_n_i = 1'b1;
    req_valid_i = 1'b0;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10 single pulse", 32'(done_o), 0);
    chk(req_ready_o == 1'b1, "R1 back idle", 32'(req_ready_o), 1);
    vec("R1 idle bus", pk(0, 0, 2'b11, 1, 1, 0, 8'h00));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    vec("R1 reset bus", pk(0, 0, 2'b11, 1, 1, 0, 8'h00));
    chk(done_o == 1'b0, "R1 reset done", 32'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 reset ready", 32'(req_ready_o), 1);
    vec("R1 idle after reset", pk(0, 0, 2'b11, 1, 1, 0, 8'h00));
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < T + 2; d++) begin
          logic [15:0] a;
          logic [7:0]  wd, rv;
          bit          sp;
          a  = 16'((c * 16'h3A17) ^ (w * 16'h0C50) ^ (d * 16'h1111) ^ 16'hA55A);
          wd = 8'(8'h3C + 8'(d * 37) + 8'(c * 5) + 8'(w * 91));
          rv = 8'(8'hC1 ^ 8'(d * 29) ^ 8'(c * 66) ^ 8'(w * 7));
          sp = bit'(((d >> 1) ^ c ^ w) & 1);
          txn(a, bit'(w), wd, bit'(c), sp, d, rv);
        end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule